// File: doc/BRIEF.md
# Serial-Loaded Feedback Divider Control Register

This block takes a three-wire serial control stream and keeps the 6-bit feedback divider setting for a clock synthesizer. The three wires are a serial clock, a serial data line and a load strobe. All three lines are asynchronous to the block. Each passes through a two-flop synchroniser into the system clock domain, where its edges are detected. Each rising serial clock edge seen while the strobe is high moves one data bit into a shift register, most-significant bit first. The falling edge of the strobe copies the shift register into the margin register.

A plain mode input picks the divider value that drives the PLL. When the mode input is low, the nominal value 50 drives it. When the mode input is high, the latched margin value drives it. A separate flag rises whenever the latched value lies outside the supported lock window of 45 to 55. A value outside that window is still applied as written.

The control pins are plain levels with no handshake. A serial frame cannot be stalled, so the sender must space its edges widely enough for the synchronisers to see every level.

Top module: `ser_div_ctrl`

## Requirements
- R1: Each rising edge of `ser_clk` seen while `ser_ld` is high shifts `ser_dat` into the 6-bit shift register at bit 0. The bits therefore arrive M5 first and M0 last, and the sixth bit ends at bit 0.
- R2: While `ser_ld` is low, toggles on `ser_clk` and `ser_dat` do not change the shift register. A later load with no clocks therefore latches the earlier contents.
- R3: A high-to-low transition of `ser_ld` copies the shift register into `div_margin`. The new value appears within 5 system clocks of the input edge.
- R4: A serial load is accepted whether `margin_en` is low or high.
- R5: While `margin_en` is high, `div_active` equals `div_margin`.
- R6: While `margin_en` is low, `div_active` equals 50 (binary 110010), whatever the value of `div_margin`.
- R7: `out_of_range` is 1 exactly when `div_margin` is below 45 or above 55. An out-of-range value still reaches `div_active` when `margin_en` is high.
- R8: After a synchronous reset, `div_margin` is 50, `out_of_range` is 0 and the shift register is 0.
- R9: A strobe fall that follows fewer than six clocks still latches the shift register as it stands. The earlier bits are moved left by the number of new bits.
- R10: `div_margin` changes only on a detected fall of `ser_ld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_ld | input | 1 | Load strobe, asynchronous; shifting is enabled while it is high, and its fall latches the value |
| margin_en | input | 1 | 1 selects the margin value, 0 selects the nominal value |
| div_active | output | 6 | Divider value applied to the PLL |
| div_margin | output | 6 | Latched margin register |
| out_of_range | output | 1 | The latched value lies outside 45..55 |

## Verification
The assertions check four rules on every cycle: a shift puts the synchronised data bit at bit 0, the shift register holds while the strobe is low, a strobe fall copies the shift register into the margin register, and the margin register holds in every other cycle. Only the bench scenarios can show the end-to-end results at the ports. These are the most-significant-first bit order, the latch latency through the synchronisers, the nominal override in each mode, the range flag at both edges of the window, and the partial-frame and ignored-clock cases.

// File: rtl/ser_div_pkg.sv
package ser_div_pkg;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned DIV_NOM = 50;
  localparam int unsigned DIV_LO  = 45;
  localparam int unsigned DIV_HI  = 55;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end
endmodule

// File: rtl/sdc_edge.sv
module sdc_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic ld_s,
  output logic clk_rise,
  output logic ld_fall
);
  logic clk_q, ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      clk_q <= clk_s;
      ld_q  <= ld_s;
    end
  end

  assign clk_rise = clk_s & ~clk_q;
  assign ld_fall  = ld_q & ~ld_s;
endmodule

// File: rtl/sdc_shifter.sv
module sdc_shifter
  import ser_div_pkg::*;
#(
  parameter int unsigned W     = DIV_W,
  parameter int unsigned RST_M = DIV_NOM
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         ld_s,
  input  logic         latch,
  output logic [W-1:0] margin
);
  localparam logic [W-1:0] RESET_VAL = RST_M[W-1:0];

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst)        margin <= RESET_VAL;
    else if (latch) margin <= sr;
  end

  // R1: a shift places the synchronised data bit at the bottom
  a_r1_shift_lsb: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !rst) |=> (sr[0] == $past(bit_in)));

  // R2: the shift register holds while the strobe is low
  a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && !rst) |=> $stable(sr));

  // R3: a strobe fall copies the shift register
  a_r3_latch_fall: assert property (@(posedge clk) disable iff (rst)
    (latch && !rst) |=> (margin == $past(sr)));

  // R10: the margin register moves only on a strobe fall
  a_r10_margin_hold: assert property (@(posedge clk) disable iff (rst)
    (!latch && !rst) |=> $stable(margin));
endmodule

// File: rtl/ser_div_ctrl.sv
module ser_div_ctrl
  import ser_div_pkg::*;
#(
  parameter int unsigned W       = DIV_W,
  parameter int unsigned NOMINAL = DIV_NOM,
  parameter int unsigned LO      = DIV_LO,
  parameter int unsigned HI      = DIV_HI,
  parameter int unsigned STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_dat,
  input  logic         ser_ld,
  input  logic         margin_en,
  output logic [W-1:0] div_active,
  output logic [W-1:0] div_margin,
  output logic         out_of_range
);
  localparam logic [W-1:0] NOM_V = NOMINAL[W-1:0];
  localparam logic [W-1:0] LO_V  = LO[W-1:0];
  localparam logic [W-1:0] HI_V  = HI[W-1:0];

  logic [2:0] sync_q;
  logic       clk_rise, ld_fall;

  sdc_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({ser_ld, ser_dat, ser_clk}),
    .q_sync(sync_q)
  );

  sdc_edge u_edge (
    .clk(clk), .rst(rst),
    .clk_s(sync_q[0]), .ld_s(sync_q[2]),
    .clk_rise(clk_rise), .ld_fall(ld_fall)
  );

  sdc_shifter #(.W(W), .RST_M(NOMINAL)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(clk_rise & sync_q[2]),
    .bit_in(sync_q[1]),
    .ld_s(sync_q[2]),
    .latch(ld_fall),
    .margin(div_margin)
  );

  assign div_active   = margin_en ? div_margin : NOM_V;
  assign out_of_range = (div_margin < LO_V) || (div_margin > HI_V);
endmodule

// File: tb/sim_ser_div_ctrl.sv
module sim_ser_div_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, margin_en = 1'b0;
  logic [5:0] div_active, div_margin;
  logic out_of_range;

  always #5 clk = ~clk;

  ser_div_ctrl u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .margin_en(margin_en), .div_active(div_active),
    .div_margin(div_margin), .out_of_range(out_of_range)
  );

  typedef struct {
    logic [5:0] margin;
    logic [5:0] active;
    logic       flag;
    string      tag;
  } exp_t;

  exp_t q[$];
  event ev_check;
  int vectors = 0, errors = 0;
  logic [5:0] model_sr = 6'd0;
  logic [5:0] model_m  = 6'd50;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(string tag);
    exp_t e;
    e.margin = model_m;
    e.active = margin_en ? model_m : 6'd50;
    e.flag   = (model_m < 6'd45) || (model_m > 6'd55);
    e.tag    = tag;
    q.push_back(e);
    -> ev_check;
    wait_n(10);
  endtask

  task automatic sclk_bit(logic b, bit update_model);
    ser_dat = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
    if (update_model) model_sr = {model_sr[4:0], b};
  endtask

  task automatic load(logic [5:0] val, int nbits, string tag);
    ser_ld = 1'b1;
    wait_n(4);
    for (int i = nbits - 1; i >= 0; i--) sclk_bit(val[i], 1'b1);
    ser_ld = 1'b0;
    model_m = model_sr;
    push_exp(tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(ev_check);
      wait_n(6);
      e = q.pop_front();
      chk({e.tag, " div_margin"}, div_margin, e.margin);
      chk({e.tag, " div_active"}, div_active, e.active);
      chk({e.tag, " out_of_range"}, out_of_range, e.flag);
    end
  end

  initial begin : driver
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    chk("R8 reset div_margin", div_margin, 50);
    chk("R8 reset div_active", div_active, 50);
    chk("R8 reset out_of_range", out_of_range, 0);
    // R8: an empty strobe after reset exposes the cleared shift register
    margin_en = 1'b1;
    load(6'd0, 0, "R8 cleared shift register");
    load(6'd55, 6, "R1 R3 R5 load 55");
    load(6'd45, 6, "R1 R5 load 45");
    load(6'd56, 6, "R7 load 56");
    load(6'd44, 6, "R7 load 44");
    load(6'd37, 6, "R1 load 37 bit order");
    margin_en = 1'b0;
    load(6'd51, 6, "R4 R6 load in nominal mode");
    margin_en = 1'b1;
    push_exp("R5 mode high after nominal load");
    // R2 R10: clocks with the strobe low are ignored
    for (int k = 0; k < 6; k++) sclk_bit(k[0], 1'b0);
    push_exp("R10 margin held with strobe low");
    load(6'd0, 0, "R2 empty strobe keeps contents");
    load(6'b000101, 3, "R9 partial frame of three bits");
    load(6'd3, 2, "R9 partial frame of two bits");
    wait_n(20);
    done = 1;
  end

  initial begin : finisher
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule